// File: doc/BRIEF.md
# Rail Fault Reaction Controller

This block watches three regulator rails for four kinds of raw fault indication: undervoltage, positive overcurrent, negative overcurrent and short-to-ground. It qualifies each indication, records it in sticky per-rail flags and group summary bits, and raises an interrupt. It also turns off the faulty rail at once and asks the power sequencer to shut everything down. The comparators that produce the raw indications and the sequencer that acts on the requests sit outside the block.

The qualification depends on what each rail is doing. A rail in the middle of a voltage transition ignores undervoltage and overcurrent. A rail that has just been enabled ignores short-to-ground for a fixed window so that its output can ramp. Overcurrent must persist for a short or a long deglitch time before it counts, and the choice is made per rail. When the sequencer is ramping toward ACTIVE, a power-down request caused by undervoltage or overcurrent waits for the end of the current sequence slot. A short-to-ground never waits. It also tells the sequencer to go back to INITIALIZE.

Top module: `rail_fault_ctrl`

## Requirements
- R1: After reset, `flags`, `grp_sum`, `irq`, `rail_off`, `pd_req` and `go_init` are all zero.
- R2: Undervoltage on rail i is qualified when `uv_raw[i]` is 1, `uv_mask[i]` is 0 and `xition_busy[i]` is 0. A qualified undervoltage sets `flags[4*i+0]` and the rail's group summary bit at the next rising edge. A masked undervoltage sets no flag, no summary bit and no power-down request.
- R3: While `xition_busy[i]` is 1, undervoltage and overcurrent on rail i are ignored, and the overcurrent deglitch count is held at zero. Detection resumes on the first edge after `xition_busy[i]` falls.
- R4: Overcurrent is confirmed on the Nth consecutive rising edge at which the unblanked raw input is 1. N is SHORT_DEGL (default 4) when `long_degl[i]` is 0 and LONG_DEGL (default 64) when it is 1. A single low cycle resets the count.
- R5: A confirmed positive overcurrent sets `flags[4*i+1]`. A confirmed negative overcurrent sets `flags[4*i+2]`. On the same edge, either one sets `rail_off[i]`. Overcurrent cannot be masked.
- R6: A short-to-ground on rail i sets `flags[4*i+3]`, `rail_off[i]`, `pd_req` and `go_init` at the next edge, whatever the sequence state. It cannot be masked.
- R7: Short-to-ground on rail i is ignored in the edge at which `rail_started[i]` is 1 and in the next SCG_BLANK (default 16) edges.
- R8: When `seq_up` is 0, a qualified undervoltage or a confirmed overcurrent sets `pd_req` at the same edge as its flag. When `seq_up` is 1, the request is held and `pd_req` rises at the first edge at which `slot_end` is 1. If `seq_up` drops first, `pd_req` rises at the next edge.
- R9: Flags and summary bits are sticky. A bit is cleared at an edge where `clr_we` is 1 and the matching bit of `clr_flags` or `clr_grp` is 1. A set in the same edge wins over the clear.
- R10: Rails 0 and 1 report to `grp_sum[0]` and rail 2 reports to `grp_sum[1]`. `irq` is 1 whenever any summary bit is 1.
- R11: `pd_req`, `go_init`, `rail_off` and any held request are released at an edge where `pwr_state` is 0 (INITIALIZE; 1 is STBY, 2 is ACTIVE) and `seq_up` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_state | input | 2 | Power state: 0 INITIALIZE, 1 STBY, 2 ACTIVE |
| seq_up | input | 1 | A sequence into ACTIVE is running |
| slot_end | input | 1 | Strobe marking the end of a sequence slot |
| uv_raw | input | 3 | Raw undervoltage per rail |
| ocp_raw | input | 3 | Raw positive overcurrent per rail |
| ocn_raw | input | 3 | Raw negative overcurrent per rail |
| scg_raw | input | 3 | Raw short-to-ground per rail |
| xition_busy | input | 3 | Rail voltage transition in progress |
| rail_started | input | 3 | One-cycle pulse when a rail is enabled |
| uv_mask | input | 3 | Undervoltage mask per rail |
| long_degl | input | 3 | Selects the long overcurrent deglitch per rail |
| clr_we | input | 1 | Write strobe for clearing |
| clr_flags | input | 12 | Write-1-to-clear bits for `flags` |
| clr_grp | input | 2 | Write-1-to-clear bits for `grp_sum` |
| flags | output | 12 | Sticky flags; bit 4*i+{0,1,2,3} = UV, OC+, OC-, SCG of rail i |
| grp_sum | output | 2 | Sticky group summary bits |
| irq | output | 1 | Interrupt: OR of the summary bits |
| rail_off | output | 3 | Per-rail immediate disable |
| pd_req | output | 1 | Power-down request to the sequencer |
| go_init | output | 1 | Request to return to INITIALIZE |

## Verification
Every output is a register, so a stimulus that is qualified in a cycle shows up after the next rising edge. This applies to undervoltage, short-to-ground, clearing and release. A confirmed overcurrent shows up after the Nth consecutive edge. A deferred power-down shows up after the edge at which `slot_end` is high. The bench drives inputs on falling edges and counts the rising edges between the stimulus and the check, then samples on the falling edge that follows. Deglitch and blanking windows are checked one edge before the due edge, where the output must still be clear, and again at the due edge.

// File: rtl/rail_fault_pkg.sv
package rail_fault_pkg;

  localparam int KINDS = 4;
  localparam int K_UV  = 0;
  localparam int K_OCP = 1;
  localparam int K_OCN = 2;
  localparam int K_SCG = 3;

  typedef enum logic [1:0] {
    PS_INIT   = 2'd0,
    PS_STBY   = 2'd1,
    PS_ACTIVE = 2'd2
  } pwr_state_e;

  // Bit position of a fault kind for a rail in the flag vector
  function automatic int flag_idx(input int rail, input int kind);
    return rail * KINDS + kind;
  endfunction

  // Rails 0 and 1 share summary group 0, later rails go to group 1
  function automatic int grp_of(input int rail);
    return (rail < 2) ? 0 : 1;
  endfunction

endpackage

// File: rtl/rf_oc_deglitch.sv
module rf_oc_deglitch #(
  parameter int SHORT_DEGL = 4,
  parameter int LONG_DEGL  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_q,
  input  logic sel_long,
  output logic hit
);
  localparam int CW = $clog2(LONG_DEGL + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] thr;

  assign thr = sel_long ? CW'(LONG_DEGL) : CW'(SHORT_DEGL);
  assign hit = raw_q && (cnt == thr - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!raw_q)     cnt <= '0;
    else if (cnt < thr)  cnt <= cnt + CW'(1);
  end

  // R4: a confirmation needs the qualified input high on the previous edge too
  assert_oc_needs_history_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(raw_q));

endmodule

// File: rtl/rf_scg_blank.sv
module rf_scg_blank #(
  parameter int SCG_BLANK = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic started,
  output logic blank
);
  localparam int BW = $clog2(SCG_BLANK + 1);

  logic [BW-1:0] cnt;

  assign blank = started || (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (started)      cnt <= BW'(SCG_BLANK);
    else if (cnt != '0)    cnt <= cnt - BW'(1);
  end

  // R7: the window is open on the edge after a start pulse
  assert_blank_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> blank);

endmodule

// File: rtl/rf_flag_bank.sv
module rf_flag_bank #(
  parameter int NFLAG = 12,
  parameter int NGRP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_flags,
  input  logic [NGRP-1:0]  set_grp,
  input  logic             clr_we,
  input  logic [NFLAG-1:0] clr_flags,
  input  logic [NGRP-1:0]  clr_grp,
  output logic [NFLAG-1:0] flags_q,
  output logic [NGRP-1:0]  grp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      grp_q   <= '0;
    end else begin
      flags_q <= (flags_q & ~(clr_we ? clr_flags : '0)) | set_flags;
      grp_q   <= (grp_q   & ~(clr_we ? clr_grp   : '0)) | set_grp;
    end
  end

  // R9: a bit can only fall when a clear was written to it
  generate
    for (genvar b = 0; b < NFLAG; b++) begin : g_fchk
      assert_clear_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_q[b]) |-> $past(clr_we && clr_flags[b]));
    end
  endgenerate

endmodule

// File: rtl/rf_pd_ctrl.sv
module rf_pd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic release_i,
  input  logic seq_up,
  input  logic slot_end,
  input  logic seq_event,
  input  logic scg_event,
  output logic pd_req,
  output logic go_init
);
  logic pend;
  logic fire;

  always_comb begin
    if (scg_event)   fire = 1'b1;
    else if (seq_up) fire = (pend || seq_event) && slot_end;
    else             fire = pend || seq_event;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_req  <= 1'b0;
      go_init <= 1'b0;
      pend    <= 1'b0;
    end else begin
      pd_req  <= (release_i ? 1'b0 : pd_req)  | fire;
      go_init <= (release_i ? 1'b0 : go_init) | scg_event;
      if (release_i || fire) pend <= 1'b0;
      else if (seq_event)    pend <= 1'b1;
    end
  end

  // R8: during a ramp the request only rises on a slot end or for a short
  assert_pd_waits_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pd_req) && $past(seq_up)) |-> $past(slot_end || scg_event));

  // R6: a return to INITIALIZE always comes with a power-down request
  assert_init_implies_pd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    go_init |-> pd_req);

endmodule

// File: rtl/rail_fault_ctrl.sv
module rail_fault_ctrl
  import rail_fault_pkg::*;
#(
  parameter int NUM_RAILS  = 3,
  parameter int SHORT_DEGL = 4,
  parameter int LONG_DEGL  = 64,
  parameter int SCG_BLANK  = 16,
  localparam int NFLAG     = NUM_RAILS * KINDS,
  localparam int NGRP      = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           pwr_state,
  input  logic                 seq_up,
  input  logic                 slot_end,
  input  logic [NUM_RAILS-1:0] uv_raw,
  input  logic [NUM_RAILS-1:0] ocp_raw,
  input  logic [NUM_RAILS-1:0] ocn_raw,
  input  logic [NUM_RAILS-1:0] scg_raw,
  input  logic [NUM_RAILS-1:0] xition_busy,
  input  logic [NUM_RAILS-1:0] rail_started,
  input  logic [NUM_RAILS-1:0] uv_mask,
  input  logic [NUM_RAILS-1:0] long_degl,
  input  logic                 clr_we,
  input  logic [NFLAG-1:0]     clr_flags,
  input  logic [NGRP-1:0]      clr_grp,
  output logic [NFLAG-1:0]     flags,
  output logic [NGRP-1:0]      grp_sum,
  output logic                 irq,
  output logic [NUM_RAILS-1:0] rail_off,
  output logic                 pd_req,
  output logic                 go_init
);
  // Named internal events
  logic [NUM_RAILS-1:0] uv_hit, ocp_hit, ocn_hit, scg_hit, scg_blank;
  logic [NFLAG-1:0]     set_flags;
  logic [NGRP-1:0]      set_grp;
  logic                 release_now;
  logic                 seq_event;

  assign release_now = (pwr_state == PS_INIT) && !seq_up;
  assign uv_hit      = uv_raw & ~uv_mask & ~xition_busy;
  assign scg_hit     = scg_raw & ~scg_blank;
  assign seq_event   = |(uv_hit | ocp_hit | ocn_hit);

  generate
    for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
      rf_oc_deglitch #(.SHORT_DEGL(SHORT_DEGL), .LONG_DEGL(LONG_DEGL)) u_ocp (
        .clk(clk), .rst_n(rst_n), .raw_q(ocp_raw[r] & ~xition_busy[r]),
        .sel_long(long_degl[r]), .hit(ocp_hit[r]));
      rf_oc_deglitch #(.SHORT_DEGL(SHORT_DEGL), .LONG_DEGL(LONG_DEGL)) u_ocn (
        .clk(clk), .rst_n(rst_n), .raw_q(ocn_raw[r] & ~xition_busy[r]),
        .sel_long(long_degl[r]), .hit(ocn_hit[r]));
      rf_scg_blank #(.SCG_BLANK(SCG_BLANK)) u_blank (
        .clk(clk), .rst_n(rst_n), .started(rail_started[r]), .blank(scg_blank[r]));

      // R2: an undervoltage flag rises only after a qualified undervoltage
      assert_uv_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[flag_idx(r, K_UV)]) |-> $past(uv_raw[r] && !uv_mask[r] && !xition_busy[r]));

      // R5: the rail is shut off only together with an OC or SCG flag
      assert_off_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_off[r]) |-> (flags[flag_idx(r, K_OCP)] || flags[flag_idx(r, K_OCN)]
                                || flags[flag_idx(r, K_SCG)]));
    end
  endgenerate

  always_comb begin
    set_flags = '0;
    set_grp   = '0;
    for (int r = 0; r < NUM_RAILS; r++) begin
      set_flags[flag_idx(r, K_UV)]  = uv_hit[r];
      set_flags[flag_idx(r, K_OCP)] = ocp_hit[r];
      set_flags[flag_idx(r, K_OCN)] = ocn_hit[r];
      set_flags[flag_idx(r, K_SCG)] = scg_hit[r];
      if (uv_hit[r] || ocp_hit[r] || ocn_hit[r] || scg_hit[r])
        set_grp[grp_of(r)] = 1'b1;
    end
  end

  rf_flag_bank #(.NFLAG(NFLAG), .NGRP(NGRP)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_flags(set_flags), .set_grp(set_grp),
    .clr_we(clr_we), .clr_flags(clr_flags), .clr_grp(clr_grp),
    .flags_q(flags), .grp_q(grp_sum));

  assign irq = |grp_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rail_off <= '0;
    else        rail_off <= (release_now ? '0 : rail_off) | ocp_hit | ocn_hit | scg_hit;
  end

  rf_pd_ctrl u_pd (
    .clk(clk), .rst_n(rst_n), .release_i(release_now), .seq_up(seq_up),
    .slot_end(slot_end), .seq_event(seq_event), .scg_event(|scg_hit),
    .pd_req(pd_req), .go_init(go_init));

endmodule

// File: tb/rail_fault_ctrl_tb.sv
module rail_fault_ctrl_tb;
  localparam int SHORT_N = 4;
  localparam int LONG_N  = 64;
  localparam int BLANK_N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pwr_state = 2'd0;
  logic seq_up = 1'b0, slot_end = 1'b0;
  logic [2:0] uv_raw = '0, ocp_raw = '0, ocn_raw = '0, scg_raw = '0;
  logic [2:0] xition_busy = '0, rail_started = '0, uv_mask = '0, long_degl = '0;
  logic clr_we = 1'b0;
  logic [11:0] clr_flags = '0;
  logic [1:0] clr_grp = '0;
  logic [11:0] flags;
  logic [1:0] grp_sum;
  logic irq, pd_req, go_init;
  logic [2:0] rail_off;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rail_fault_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .seq_up(seq_up),
    .slot_end(slot_end), .uv_raw(uv_raw), .ocp_raw(ocp_raw), .ocn_raw(ocn_raw),
    .scg_raw(scg_raw), .xition_busy(xition_busy), .rail_started(rail_started),
    .uv_mask(uv_mask), .long_degl(long_degl), .clr_we(clr_we), .clr_flags(clr_flags),
    .clr_grp(clr_grp), .flags(flags), .grp_sum(grp_sum), .irq(irq),
    .rail_off(rail_off), .pd_req(pd_req), .go_init(go_init));

  function automatic int fbit(input int rail, input int kind);
    return 4 * rail + kind;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle_clear();
    uv_raw = '0; ocp_raw = '0; ocn_raw = '0; scg_raw = '0; xition_busy = '0;
    seq_up = 0; slot_end = 0; pwr_state = 2'd0;
    clr_we = 1; clr_flags = '1; clr_grp = '1;
    step();
    clr_we = 0; clr_flags = '0; clr_grp = '0;
    step();
  endtask

  task automatic t_reset();
    chk("R1", "flags", 32'(flags), 0);
    chk("R1", "irq/pd/init", {29'd0, irq, pd_req, go_init}, 0);
    chk("R1", "rail_off", 32'(rail_off), 0);
  endtask

  task automatic t_uv_basic();
    pwr_state = 2'd2;
    uv_raw[0] = 1; step(); uv_raw[0] = 0;
    chk("R2", "uv flag rail0", 32'(flags), 32'(1) << fbit(0, 0));
    chk("R10", "grp_sum", 32'(grp_sum), 1);
    chk("R10", "irq", 32'(irq), 1);
    chk("R8", "pd_req immediate", 32'(pd_req), 1);
    chk("R8", "no go_init", 32'(go_init), 0);
    pwr_state = 2'd0; step();
    chk("R11", "pd released", 32'(pd_req), 0);
    chk("R9", "flag sticky", 32'(flags), 32'(1) << fbit(0, 0));
    clr_we = 1; clr_flags = 12'h001; clr_grp = 2'b01; step(); clr_we = 0;
    chk("R9", "cleared flags", 32'(flags), 0);
    chk("R10", "irq clear", 32'(irq), 0);
    settle_clear();
  endtask

  task automatic t_uv_masked();
    pwr_state = 2'd2; uv_mask = 3'b100;
    uv_raw[2] = 1; step(3); uv_raw[2] = 0;
    chk("R2", "masked uv flags", 32'(flags), 0);
    chk("R2", "masked uv pd", {30'd0, pd_req, irq}, 0);
    uv_mask = '0;
    settle_clear();
  endtask

  task automatic t_uv_blank();
    pwr_state = 2'd1; xition_busy[1] = 1; uv_raw[1] = 1; step(3);
    chk("R3", "uv blanked", 32'(flags), 0);
    xition_busy[1] = 0; step();
    chk("R3", "uv after transition", 32'(flags), 32'(1) << fbit(1, 0));
    chk("R10", "rail1 group0", 32'(grp_sum), 1);
    uv_raw[1] = 0;
    settle_clear();
  endtask

  task automatic t_oc_short();
    pwr_state = 2'd2; ocp_raw[1] = 1; step(SHORT_N - 1);
    chk("R4", "short deglitch early", 32'(flags), 0);
    chk("R4", "no off early", 32'(rail_off), 0);
    step();
    chk("R5", "ocp flag rail1", 32'(flags), 32'(1) << fbit(1, 1));
    chk("R5", "rail_off rail1", 32'(rail_off), 3'b010);
    chk("R8", "pd on oc", 32'(pd_req), 1);
    ocp_raw[1] = 0; step();
    chk("R11", "rail_off held", 32'(rail_off), 3'b010);
    settle_clear();
    chk("R11", "rail_off released", 32'(rail_off), 0);
  endtask

  task automatic t_oc_long();
    pwr_state = 2'd2; long_degl[2] = 1; ocn_raw[2] = 1; step(LONG_N - 1);
    chk("R4", "long deglitch early", 32'(flags), 0);
    ocn_raw[2] = 0; step();
    ocn_raw[2] = 1; step(LONG_N - 1);
    chk("R4", "count restarted", 32'(flags), 0);
    step();
    chk("R5", "ocn flag rail2", 32'(flags), 32'(1) << fbit(2, 2));
    chk("R10", "rail2 group1", 32'(grp_sum), 2'b10);
    chk("R5", "rail_off rail2", 32'(rail_off), 3'b100);
    ocn_raw[2] = 0; long_degl = '0;
    settle_clear();
  endtask

  task automatic t_oc_blank();
    pwr_state = 2'd2; xition_busy[0] = 1; ocp_raw[0] = 1; step(10);
    chk("R3", "oc blanked", 32'(flags), 0);
    xition_busy[0] = 0; step(SHORT_N - 1);
    chk("R3", "oc rearm count", 32'(flags), 0);
    step();
    chk("R3", "oc after rearm", 32'(flags), 32'(1) << fbit(0, 1));
    ocp_raw[0] = 0;
    settle_clear();
  endtask

  task automatic t_scg();
    pwr_state = 2'd2; seq_up = 1;
    rail_started[0] = 1; scg_raw[0] = 1; step();
    rail_started[0] = 0; step(BLANK_N);
    chk("R7", "scg blanked", 32'(flags), 0);
    step();
    chk("R6", "scg flag", 32'(flags), 32'(1) << fbit(0, 3));
    chk("R6", "scg off/pd/init", {29'd0, rail_off[0], pd_req, go_init}, 3'b111);
    scg_raw[0] = 0;
    settle_clear();
    chk("R11", "go_init released", 32'(go_init), 0);
  endtask

  task automatic t_defer();
    pwr_state = 2'd0; seq_up = 1;
    uv_raw[0] = 1; step(); uv_raw[0] = 0;
    chk("R8", "uv flag in sequence", 32'(flags), 1);
    step(3);
    chk("R8", "pd deferred", 32'(pd_req), 0);
    slot_end = 1; step(); slot_end = 0;
    chk("R8", "pd at slot end", 32'(pd_req), 1);
    settle_clear();
    seq_up = 1; uv_raw[1] = 1; step(); uv_raw[1] = 0; step();
    chk("R8", "pd still held", 32'(pd_req), 0);
    seq_up = 0; pwr_state = 2'd2; step();
    chk("R8", "pd when sequence ends", 32'(pd_req), 1);
    settle_clear();
  endtask

  task automatic t_set_wins();
    pwr_state = 2'd2; uv_raw[2] = 1;
    clr_we = 1; clr_flags = '1; clr_grp = '1; step(); step();
    chk("R9", "set beats clear", 32'(flags), 32'(1) << fbit(2, 0));
    chk("R9", "grp set beats clear", 32'(grp_sum), 2'b10);
    clr_we = 0; clr_flags = '0; clr_grp = '0; uv_raw[2] = 0;
    settle_clear();
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step();
    t_reset();
    t_uv_basic();
    t_uv_masked();
    t_uv_blank();
    t_oc_short();
    t_oc_long();
    t_oc_blank();
    t_scg();
    t_defer();
    t_set_wins();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule